// File: doc/BRIEF.md
# Dynamic VID Transition Supervisor

This block watches the voltage-identification (VID) code while a multiphase buck regulator is in normal operation. Any difference between the code on its input and the code it sampled on the previous clock counts as one step of a commanded voltage transition. The transition stays open until two conditions both hold: the code has been quiet for a programmable settle time, and the DAC code has reached the new target.

While the latest step was upward, the block raises the overcurrent threshold to a boosted scale and selects the overvoltage limit used for the highest VID code. Without this, the ramp's inrush current or its overshoot could trip the protection circuits falsely. In both directions it forces the effective low-power (phase-shedding) state off from the first step onward. It gives low-power mode back only after a fixed wait of about 50 µs that starts when the transition completes, and only if low-power is still requested then. The threshold comparators and the phase dropping are outside this block. It only drives the selects that those circuits use.

Top module: `vid_transition_supervisor`

## Requirements
- R1: In reset, `ocp_pct` equals NORM_PCT (100), `ovp_max_sel` is 0, `lowpwr_eff` is 0 and `trans_active` is 0. The VID register loads the present input, so releasing reset does not count as a step.
- R2: On the first clock edge at which `vid_code` differs from the code sampled at the previous edge, `trans_active` becomes 1.
- R3: A numerically larger `vid_code` means a higher voltage. When the most recent step of an open transition was upward, `ocp_pct` equals BOOST_PCT (240, which is 140 % above nominal).
- R4: When the most recent step of an open transition was upward, `ovp_max_sel` is 1.
- R5: When the most recent step was downward, `ocp_pct` stays at NORM_PCT and `ovp_max_sel` stays 0, while `trans_active` is 1.
- R6: `lowpwr_eff` is 0 from the edge that registers a step, through the whole transition and the whole resume wait.
- R7: The transition completes at the edge where the code has been unchanged for SETTLE_CYC edges after the last step and `dac_code` equals `vid_code`. At that edge `trans_active` and both boosts drop.
- R8: While `dac_code` differs from `vid_code`, the transition stays open no matter how long the code is quiet.
- R9: After completion the block waits RESUME_CYC+1 edges (RESUME_CYC = 50 µs of clock) and then passes `lowpwr_req` through. If the request is low by then, `lowpwr_eff` stays 0.
- R10: A VID step during the resume wait cancels the wait and reopens the transition at that edge.
- R11: A further step inside an open transition restarts the settle count, and the threshold boost follows the direction of that latest step.
- R12: Outside any transition or wait, `lowpwr_eff` follows `lowpwr_req` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vid_code | input | VID_W | Commanded VID code, larger means higher voltage |
| dac_code | input | VID_W | Code the reference DAC presently outputs |
| lowpwr_req | input | 1 | Low-power (phase-shedding) request, active high |
| ocp_pct | output | PCT_W | Overcurrent threshold scale in percent of nominal |
| ovp_max_sel | output | 1 | Select the overvoltage limit of the highest VID |
| lowpwr_eff | output | 1 | Effective low-power state to the phase logic |
| trans_active | output | 1 | A VID transition is open |

## Verification
The embedded assertions check four properties on every cycle:
- A registered step always turns low-power off on the next edge.
- A boosted current limit never appears without the overvoltage select.
- A downward step never leaves a boost behind.
- A transition can close only after an edge at which the DAC matched the target.

The exact length of the settle window, the resume wait, the cancel of the wait by a new step and the return of the request afterwards can only be shown by the bench's scenarios. There, a behavioural model counts the edges and the outputs are compared against it on every clock.

// File: rtl/dvid_pkg.sv
package dvid_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_TRANS  = 2'd1,
    ST_RESUME = 2'd2
  } dvid_state_e;
endpackage

// File: rtl/dvid_step_detect.sv
module dvid_step_detect #(
  parameter int VID_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VID_W-1:0] vid_code,
  output logic             step,
  output logic             step_up
);
  logic [VID_W-1:0] vid_q;

  always_ff @(posedge clk) begin
    vid_q <= vid_code;
  end

  assign step    = (vid_code != vid_q) && !rst;
  assign step_up = vid_code > vid_q;
endmodule

// File: rtl/dvid_window_timer.sv
module dvid_window_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LIM);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);
endmodule

// File: rtl/dvid_ctrl.sv
module dvid_ctrl
  import dvid_pkg::*;
#(
  parameter int PCT_W     = 9,
  parameter int NORM_PCT  = 100,
  parameter int BOOST_PCT = 240
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             step_up,
  input  logic             settled,
  input  logic             dac_match,
  input  logic             resume_done,
  input  logic             lowpwr_req,
  output dvid_state_e      state,
  output logic [PCT_W-1:0] ocp_pct,
  output logic             ovp_max_sel,
  output logic             lowpwr_eff,
  output logic             trans_active
);
  localparam logic [PCT_W-1:0] P_NORM  = PCT_W'(NORM_PCT);
  localparam logic [PCT_W-1:0] P_BOOST = PCT_W'(BOOST_PCT);

  dvid_state_e nxt;
  logic        dir_up, nxt_up, boost_n;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (step) nxt = ST_TRANS;
      ST_TRANS:  if (!step && settled && dac_match) nxt = ST_RESUME;
      ST_RESUME: if (step) nxt = ST_TRANS;
                 else if (resume_done) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign nxt_up  = step ? step_up : dir_up;
  assign boost_n = (nxt == ST_TRANS) && nxt_up;

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      dir_up       <= 1'b0;
      ocp_pct      <= P_NORM;
      ovp_max_sel  <= 1'b0;
      lowpwr_eff   <= 1'b0;
      trans_active <= 1'b0;
    end else begin
      state        <= nxt;
      dir_up       <= nxt_up;
      ocp_pct      <= boost_n ? P_BOOST : P_NORM;
      ovp_max_sel  <= boost_n;
      lowpwr_eff   <= (nxt == ST_IDLE) && lowpwr_req;
      trans_active <= (nxt == ST_TRANS);
    end
  end

  // R6
  step_forces_lowpwr_off_chk: assert property (@(posedge clk) disable iff (rst)
    step |=> !lowpwr_eff);
  // R4
  boost_pairs_ovp_chk: assert property (@(posedge clk) disable iff (rst)
    (ocp_pct == P_BOOST) |-> ovp_max_sel);
  // R5
  down_step_no_boost_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !step_up) |=> (ocp_pct == P_NORM && !ovp_max_sel));
  // R8
  close_needs_dac_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RESUME && $past(state) == ST_TRANS) |-> $past(dac_match));
endmodule

// File: rtl/vid_transition_supervisor.sv
module vid_transition_supervisor
  import dvid_pkg::*;
#(
  parameter int VID_W      = 8,
  parameter int PCT_W      = 9,
  parameter int NORM_PCT   = 100,
  parameter int BOOST_PCT  = 240,
  parameter int SETTLE_CYC = 20,
  parameter int CLK_MHZ    = 4,
  parameter int RESUME_US  = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VID_W-1:0] vid_code,
  input  logic [VID_W-1:0] dac_code,
  input  logic             lowpwr_req,
  output logic [PCT_W-1:0] ocp_pct,
  output logic             ovp_max_sel,
  output logic             lowpwr_eff,
  output logic             trans_active
);
  localparam int RESUME_CYC = CLK_MHZ * RESUME_US;

  logic        step, step_up, settled, resume_done;
  dvid_state_e state;

  dvid_step_detect #(.VID_W(VID_W)) u_detect (
    .clk(clk), .rst(rst), .vid_code(vid_code),
    .step(step), .step_up(step_up)
  );

  dvid_window_timer #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .rst(rst), .clr(step || state == ST_IDLE), .done(settled)
  );

  dvid_window_timer #(.LIMIT(RESUME_CYC)) u_resume (
    .clk(clk), .rst(rst), .clr(state != ST_RESUME), .done(resume_done)
  );

  dvid_ctrl #(.PCT_W(PCT_W), .NORM_PCT(NORM_PCT), .BOOST_PCT(BOOST_PCT)) u_ctrl (
    .clk(clk), .rst(rst), .step(step), .step_up(step_up),
    .settled(settled), .dac_match(dac_code == vid_code),
    .resume_done(resume_done), .lowpwr_req(lowpwr_req),
    .state(state), .ocp_pct(ocp_pct), .ovp_max_sel(ovp_max_sel),
    .lowpwr_eff(lowpwr_eff), .trans_active(trans_active)
  );
endmodule

// File: tb/vid_transition_supervisor_test.sv
module vid_transition_supervisor_test;
  localparam int CLK_PERIOD = 10;
  localparam int S = 20;
  localparam int R = 200;

  logic       clk = 0, rst = 1, lowpwr_req = 0;
  logic [7:0] vid_code = 8'd100, dac_code = 8'd100;
  logic [8:0] ocp_pct;
  logic       ovp_max_sel, lowpwr_eff, trans_active;

  vid_transition_supervisor uut (
    .clk(clk), .rst(rst), .vid_code(vid_code), .dac_code(dac_code),
    .lowpwr_req(lowpwr_req), .ocp_pct(ocp_pct), .ovp_max_sel(ovp_max_sel),
    .lowpwr_eff(lowpwr_eff), .trans_active(trans_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, errors = 0, cyc = 0;
  bit finished = 0, armed = 0;
  int m_st = 0, m_prev = 0, m_up = 0, m_sc = 0, m_rc = 0;
  int e_ocp = 100, e_ovp = 0, e_lp = 0, e_tr = 0;

  // Behavioural model, updated on each rising edge from stable inputs.
  always @(posedge clk) begin
    int nst, nup; bit chg;
    armed = 1;
    if (rst) begin
      m_st = 0; m_prev = vid_code; m_up = 0; m_sc = 0; m_rc = 0;
      e_ocp = 100; e_ovp = 0; e_lp = 0; e_tr = 0;
    end else begin
      chg = (int'(vid_code) != m_prev);
      nup = chg ? int'(int'(vid_code) > m_prev) : m_up;
      nst = m_st;
      if (m_st == 0 && chg) nst = 1;
      else if (m_st == 1 && !chg && m_sc == S && dac_code == vid_code) nst = 2;
      else if (m_st == 2) nst = chg ? 1 : (m_rc == R ? 0 : 2);
      if (chg || m_st == 0) m_sc = 0; else if (m_sc < S) m_sc++;
      if (m_st != 2) m_rc = 0; else if (m_rc < R) m_rc++;
      m_st = nst; m_up = nup; m_prev = vid_code;
      e_ocp = (nst == 1 && nup == 1) ? 240 : 100;
      e_ovp = (nst == 1 && nup == 1);
      e_lp  = (nst == 0) && lowpwr_req;
      e_tr  = (nst == 1);
    end
  end

  always @(negedge clk) if (armed && !finished) begin
    vectors++;
    if (int'(ocp_pct) != e_ocp) begin errors++;
      $display("FAIL R3 ocp_pct actual %0d expected %0d cycle %0d", ocp_pct, e_ocp, cyc); end
    if (int'(ovp_max_sel) != e_ovp) begin errors++;
      $display("FAIL R4 ovp_max_sel actual %0d expected %0d cycle %0d", ovp_max_sel, e_ovp, cyc); end
    if (int'(lowpwr_eff) != e_lp) begin errors++;
      $display("FAIL R6 lowpwr_eff actual %0d expected %0d cycle %0d", lowpwr_eff, e_lp, cyc); end
    if (int'(trans_active) != e_tr) begin errors++;
      $display("FAIL R2 trans_active actual %0d expected %0d cycle %0d", trans_active, e_tr, cyc); end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      finished = 1; errors++;
      $display("FAIL watchdog actual %0d expected below 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic set_in(input int v, input int d, input bit q);
    @(negedge clk); #1;
    vid_code = 8'(v); dac_code = 8'(d); lowpwr_req = q;
  endtask

  initial begin
    // R1: reset values compared on every edge while rst is high
    wait_cyc(4);
    rst = 0;
    // R12: request passes through in idle
    set_in(100, 100, 1); wait_cyc(6);
    set_in(100, 100, 0); wait_cyc(3);
    set_in(100, 100, 1); wait_cyc(4);
    // R2 R3 R4 R6: upward steps with the DAC lagging one code
    for (int i = 1; i <= 4; i++) begin
      set_in(100 + i, 99 + i, 1); wait_cyc(4);
    end
    // R8: code quiet well past SETTLE_CYC while the DAC is short of target
    wait_cyc(3 * S);
    // R7: DAC reaches the target, completion after the settle window
    set_in(104, 104, 1); wait_cyc(S + 5);
    // R9: resume wait, then low-power returns
    wait_cyc(R + 10);
    // R10: new transition, then a step in the middle of the resume wait
    set_in(105, 105, 1); wait_cyc(S + 10);
    wait_cyc(R / 2);
    set_in(106, 106, 1); wait_cyc(S + 5);
    wait_cyc(R + 5);
    // R5: downward steps, thresholds stay normal
    for (int i = 1; i <= 3; i++) begin
      set_in(106 - i, 106 - i, 1); wait_cyc(5);
    end
    // R11: up then down in the same transition, boost follows the last step
    set_in(104, 103, 1); wait_cyc(3);
    set_in(103, 103, 1); wait_cyc(S / 2);
    set_in(104, 104, 1); wait_cyc(S + 4);
    // R9: request dropped during the wait keeps low-power off
    set_in(104, 104, 0); wait_cyc(R + 10);
    set_in(104, 104, 1); wait_cyc(5);
    // R1: reset in the middle of a transition
    set_in(110, 104, 1); wait_cyc(3);
    rst = 1; wait_cyc(3);
    rst = 0; wait_cyc(5);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule